// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Cycle Engine

This block runs SPI flash transactions on behalf of software, which never drives raw SPI bytes itself. Software first fills a table of eight one-byte opcodes and a 2-bit cycle type for each entry. To start a cycle it writes a control word that holds a menu index, an optional data phase and a byte count. The address comes from a separate register, and any write data comes from a 64-byte buffer. The engine builds the frame from these: the opcode, then three address bytes if the type needs them, then the data. It shifts the frame out MSB first in SPI mode 0. Read data is captured back into the same buffer.

An optional prefix opcode, typically a write enable, can be sent as a separate one-byte frame just before the main frame. No other access can come between the two. Once software sets the lockdown bit, the opcode table, the type table and the prefix opcode can no longer be changed until reset. Completion and failure are reported through sticky flags that software clears by writing 1. A protection checker outside the block can veto a cycle at start. In that case the error flag is set and no SPI activity takes place.

Top module: `spi_menu_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, the status word reads 0, the lock bit reads 0 and the opcode table reads 0.
- R2: Writing control (register 0) with bit 0 set starts a cycle. Bits 6:4 select the menu entry, and that entry's opcode is the first byte of the main frame. Bytes are sent MSB first in SPI mode 0: the clock idles low, data changes while the clock is low, and the device samples on the rising edge.
- R3: Entry i takes its type from bits 2i+1:2i of the type register (register 5). Type 0 is read without address, 1 is write without address, 2 is read with address and 3 is write with address. Types 2 and 3 send the address bits 23:16, 15:8 and 7:0 right after the opcode. Only bits 23:0 of the address register (register 2) are stored or used.
- R4: With control bit 7 set, a data phase of (bits 13:8)+1 bytes follows. For write types, buffer bytes 0 upward are sent, where buffer byte k is held at register 8+k/4 in bits 8*(k%4)+7:8*(k%4).
- R5: For read types, the data phase sends 0x00 and stores each received byte in the buffer from byte 0 upward.
- R6: With control bit 1 set, the prefix opcode (register 6) is sent first as a one-byte frame. Chip select then stays high for at least one SPI clock period, and the main frame follows.
- R7: Register 1 reads busy in bit 0, done in bit 1 and error in bit 2. Done is set when a cycle completes. Writing 1 to bit 1 or bit 2 clears that flag.
- R8: A start request made while busy is ignored and sets the error flag. The running cycle finishes unchanged.
- R9: A start request made while prot_deny is high sets the error flag, leaves the engine idle and produces no SPI frame.
- R10: Writing 1 to bit 0 of register 7 sets the lock. While it is set, writes to the opcode table (registers 3 and 4), the type register and the prefix register are ignored. The lock is cleared only by reset, and other registers stay writable.
- R11: Control bit 2 picks the SPI clock. With the bit at 1, each half period lasts HALF_FAST system clocks; with the bit at 0, it lasts HALF_SLOW system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| prot_deny | input | 1 | Protection checker veto, sampled at cycle start |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check, on every cycle, properties that must hold at all times. The clock stays low while chip select is high, and the output data holds steady while the clock is high. Once set, the lock never drops. A start request refused because the engine is busy or because prot_deny is high always raises the error flag, and a vetoed request never leaves the engine busy. Only the bench scenarios can show what the frames contain: the byte order of opcode, address and data, the read data landing in the buffer, the gap between the prefix and main frames, the clock period for each speed setting, and that the lock leaves the opcodes actually sent unchanged.

// File: rtl/spi_menu_engine.sv
module spi_menu_engine #(
  parameter int BUF_BYTES = 64,
  parameter int HALF_SLOW = 3,
  parameter int HALF_FAST = 2,
  localparam int CW     = $clog2(BUF_BYTES),
  localparam int DWORDS = BUF_BYTES / 4,
  localparam int AW     = $clog2(8 + DWORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          prot_deny,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int FLW  = CW + 2;
  localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int HW   = $clog2(HMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_GAP, S_MAIN} st_t;

  st_t            st;
  logic [7:0]     menu [8];
  logic [15:0]    optype;
  logic [7:0]     prefix;
  logic           lock_r, done_r, err_r;
  logic [23:0]    addr_r;
  logic [CW+7:0]  ctrl_r;
  logic [7:0]     dbuf [BUF_BYTES];

  logic [7:0]     c_op;
  logic [1:0]     c_type;
  logic           c_dp, c_fast;
  logic [CW-1:0]  c_cnt1;
  logic [23:0]    c_addr;
  logic [FLW-1:0] flen, byte_idx;
  logic [2:0]     bit_cnt;
  logic [7:0]     shreg, rxreg;
  logic           sck_r;
  logic [HW-1:0]  hcnt;

  wire busy    = st != S_IDLE;
  wire go_wr   = reg_we && reg_addr == AW'(0) && reg_wdata[0];
  wire go_ok   = go_wr && !busy && !prot_deny;
  wire is_data = reg_addr >= AW'(8) && 32'(reg_addr) < 8 + DWORDS;
  wire [CW-3:0] woff = (CW-2)'(reg_addr - AW'(8));

  wire [2:0]     n_idx  = reg_wdata[6:4];
  wire [1:0]     n_type = optype[{n_idx, 1'b0} +: 2];
  wire [CW-1:0]  n_cnt1 = reg_wdata[CW+7:8];
  wire [FLW-1:0] n_len  = (n_type[1] ? FLW'(4) : FLW'(1)) +
                          (reg_wdata[7] ? FLW'(n_cnt1) + FLW'(1) : FLW'(0));
  wire [FLW-1:0] c_hdr  = c_type[1] ? FLW'(4) : FLW'(1);
  wire [FLW-1:0] c_len  = c_hdr + (c_dp ? FLW'(c_cnt1) + FLW'(1) : FLW'(0));

  wire [HW-1:0]  half      = c_fast ? HW'(HALF_FAST) : HW'(HALF_SLOW);
  wire           tick      = busy && (hcnt == half - HW'(1));
  wire [FLW-1:0] nxt_pos   = byte_idx + FLW'(1);
  wire [CW-1:0]  nxt_dpos  = CW'(nxt_pos - c_hdr);
  wire           last_bit  = tick && sck_r && bit_cnt == 3'd7;
  wire           frame_end = last_bit && nxt_pos == flen;
  wire           cap_en    = st == S_MAIN && last_bit && c_dp && !c_type[0] &&
                             byte_idx >= c_hdr;
  wire [CW-1:0]  cap_pos   = CW'(byte_idx - c_hdr);

  logic [7:0] nxt_byte;
  always_comb begin
    if (c_type[1] && nxt_pos < FLW'(4)) begin
      case (nxt_pos[1:0])
        2'd1:    nxt_byte = c_addr[23:16];
        2'd2:    nxt_byte = c_addr[15:8];
        default: nxt_byte = c_addr[7:0];
      endcase
    end else if (c_type[0]) begin
      nxt_byte = dbuf[nxt_dpos];
    end else begin
      nxt_byte = 8'h00;
    end
  end

  assign spi_sck  = sck_r;
  assign spi_cs_n = !(st == S_PRE || st == S_MAIN);
  assign spi_mosi = spi_cs_n ? 1'b0 : shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) menu[i] <= 8'h00;
      optype <= '0;
      prefix <= '0;
      lock_r <= 1'b0;
      addr_r <= '0;
      ctrl_r <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AW'(0): ctrl_r <= {reg_wdata[CW+7:1], 1'b0};
        AW'(2): addr_r <= reg_wdata[23:0];
        AW'(3): if (!lock_r) for (int i = 0; i < 4; i++) menu[i]   <= reg_wdata[8*i +: 8];
        AW'(4): if (!lock_r) for (int i = 0; i < 4; i++) menu[i+4] <= reg_wdata[8*i +: 8];
        AW'(5): if (!lock_r) optype <= reg_wdata[15:0];
        AW'(6): if (!lock_r) prefix <= reg_wdata[7:0];
        AW'(7): if (reg_wdata[0]) lock_r <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (reg_we && is_data)
      for (int k = 0; k < 4; k++) dbuf[{woff, 2'(k)}] <= reg_wdata[8*k +: 8];
    if (cap_en) dbuf[cap_pos] <= rxreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done_r <= 1'b0; err_r <= 1'b0;
      c_op <= '0; c_type <= '0; c_dp <= 1'b0; c_fast <= 1'b0; c_cnt1 <= '0; c_addr <= '0;
      flen <= '0; byte_idx <= '0; bit_cnt <= '0; shreg <= '0; rxreg <= '0;
      sck_r <= 1'b0; hcnt <= '0;
    end else begin
      if (reg_we && reg_addr == AW'(1)) begin
        if (reg_wdata[1]) done_r <= 1'b0;
        if (reg_wdata[2]) err_r  <= 1'b0;
      end
      if (go_wr && (busy || prot_deny)) err_r <= 1'b1;
      hcnt <= (!busy || tick) ? '0 : hcnt + HW'(1);
      case (st)
        S_IDLE: if (go_ok) begin
          c_op     <= menu[n_idx];
          c_type   <= n_type;
          c_dp     <= reg_wdata[7];
          c_fast   <= reg_wdata[2];
          c_cnt1   <= n_cnt1;
          c_addr   <= addr_r;
          byte_idx <= '0;
          bit_cnt  <= '0;
          sck_r    <= 1'b0;
          if (reg_wdata[1]) begin
            st <= S_PRE; shreg <= prefix; flen <= FLW'(1);
          end else begin
            st <= S_MAIN; shreg <= menu[n_idx]; flen <= n_len;
          end
        end
        S_PRE, S_MAIN: if (tick) begin
          if (!sck_r) begin
            sck_r <= 1'b1;
            rxreg <= {rxreg[6:0], spi_miso};
          end else begin
            sck_r <= 1'b0;
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              if (frame_end) begin
                if (st == S_PRE) st <= S_GAP;
                else begin st <= S_IDLE; done_r <= 1'b1; end
              end else begin
                byte_idx <= nxt_pos;
                shreg    <= nxt_byte;
              end
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              shreg   <= {shreg[6:0], 1'b0};
            end
          end
        end
        S_GAP: if (tick) begin
          if (bit_cnt[0]) begin
            st <= S_MAIN; bit_cnt <= '0; byte_idx <= '0;
            shreg <= c_op; flen <= c_len;
          end else begin
            bit_cnt <= 3'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata[CW+7:0] = ctrl_r;
      AW'(1): reg_rdata[2:0]    = {err_r, done_r, busy};
      AW'(2): reg_rdata[23:0]   = addr_r;
      AW'(3): reg_rdata = {menu[3], menu[2], menu[1], menu[0]};
      AW'(4): reg_rdata = {menu[7], menu[6], menu[5], menu[4]};
      AW'(5): reg_rdata[15:0]   = optype;
      AW'(6): reg_rdata[7:0]    = prefix;
      AW'(7): reg_rdata[0]      = lock_r;
      default: if (is_data)
        for (int k = 0; k < 4; k++) reg_rdata[8*k +: 8] = dbuf[{woff, 2'(k)}];
    endcase
  end
endmodule

// File: rtl/spi_menu_engine_chk.sv
module spi_menu_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic go_wr,
  input logic prot_deny,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic lock,
  input logic err
);
  // R2
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R8
  busy_go_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy) |=> err);

  // R9
  deny_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && !busy && prot_deny) |=> (err && !busy && cs_n));

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
endmodule

bind spi_menu_engine spi_menu_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .go_wr(go_wr), .prot_deny(prot_deny),
  .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .lock(lock_r), .err(err_r)
);

// File: tb/spi_menu_engine_tb.sv
`timescale 1ns/1ps
module spi_menu_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, prot_deny = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  spi_menu_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prot_deny(prot_deny),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // flash model
  int fcnt = 0, bitpos = 0, bytepos = 0;
  int flen_m [4];
  logic [7:0] fb [4][80];
  logic [7:0] msh = '0;
  time t_rise = 0, t_pos = 0, gap_ns = 0, per_ns = 0;
  logic [7:0] miso_b;
  assign miso_b   = 8'hC3 ^ 8'(bytepos);
  assign spi_miso = miso_b[3'(7 - bitpos)];

  always @(negedge spi_cs_n) begin
    bitpos = 0; bytepos = 0;
    if (fcnt > 0) gap_ns = $time - t_rise;
  end
  always @(posedge spi_cs_n) begin
    if (fcnt < 4) flen_m[fcnt] = bytepos;
    fcnt++; t_rise = $time;
  end
  always @(posedge spi_sck) begin
    per_ns = $time - t_pos; t_pos = $time;
    msh = {msh[6:0], spi_mosi};
    bitpos++;
    if (bitpos == 8) begin
      if (fcnt < 4 && bytepos < 80) fb[fcnt][bytepos] = msh;
      bytepos++; bitpos = 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 6000; i++) begin
      rd(5'd1, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [7:0] menu_op(input int i);
    return 8'h81 + 8'(i) * 8'h13;
  endfunction
  function automatic logic [7:0] bpat(input int k, input int v);
    return 8'(k * 5 + v * 17 + 1);
  endfunction

  task automatic fill_buf(input int v);
    for (int w = 0; w < 16; w++)
      wr(5'(8 + w), {bpat(4*w+3, v), bpat(4*w+2, v), bpat(4*w+1, v), bpat(4*w, v)});
  endtask

  task automatic clear_mon();
    fcnt = 0; gap_ns = 0;
  endtask

  typedef struct packed {
    logic [2:0]  idx;
    logic [23:0] adr;
    logic        dp;
    logic [5:0]  c1;
    logic        at;
    logic        fs;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{3'd1, 24'h000000, 1'b0, 6'd0,  1'b0, 1'b1},
    '{3'd2, 24'h123456, 1'b1, 6'd3,  1'b0, 1'b1},
    '{3'd3, 24'hABCDEF, 1'b1, 6'd5,  1'b1, 1'b1},
    '{3'd0, 24'h000000, 1'b1, 6'd1,  1'b0, 1'b0},
    '{3'd7, 24'h000100, 1'b1, 6'd63, 1'b0, 1'b1},
    '{3'd5, 24'h000000, 1'b1, 6'd0,  1'b1, 1'b0}
  };

  logic [7:0] ex [2][80];
  int exl [2];

  initial begin : wdog
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(spi_cs_n === 1'b1, "R1", "cs_n", 32'(spi_cs_n), 1);
    check(spi_sck === 1'b0, "R1", "sck", 32'(spi_sck), 0);
    rd(5'd1, d); check(d === 0, "R1", "status", d, 0);
    rd(5'd7, d); check(d === 0, "R1", "lock", d, 0);
    rd(5'd3, d); check(d === 0, "R1", "menu", d, 0);

    wr(5'd3, {menu_op(3), menu_op(2), menu_op(1), menu_op(0)});
    wr(5'd4, {menu_op(7), menu_op(6), menu_op(5), menu_op(4)});
    wr(5'd5, 32'h0000E4E4);
    wr(5'd6, 32'h00000006);

    // R3 address register keeps only 24 bits
    wr(5'd2, 32'hFF123456); rd(5'd2, d);
    check(d === 32'h00123456, "R3", "addr readback", d, 32'h00123456);

    for (int vn = 0; vn < 6; vn++) begin
      vec_t v; int ty, hdr, nf, bad, hp; string tag;
      v = VT[vn]; ty = int'(v.idx) % 4; hdr = (ty >= 2) ? 4 : 1;
      hp = v.fs ? 2 : 3;
      nf = 0;
      if (v.at) begin ex[0][0] = 8'h06; exl[0] = 1; nf = 1; end
      exl[nf] = 0;
      ex[nf][exl[nf]++] = menu_op(int'(v.idx));
      if (ty >= 2) begin
        ex[nf][exl[nf]++] = v.adr[23:16];
        ex[nf][exl[nf]++] = v.adr[15:8];
        ex[nf][exl[nf]++] = v.adr[7:0];
      end
      if (v.dp)
        for (int j = 0; j <= int'(v.c1); j++)
          ex[nf][exl[nf]++] = (ty % 2 == 1) ? bpat(j, vn) : 8'h00;
      nf++;
      tag = v.at ? "R6" : (ty >= 2 ? "R3" : (v.dp && ty == 1 ? "R4" : (v.dp ? "R5" : "R2")));

      fill_buf(vn);
      wr(5'd2, {8'hFF, v.adr});
      clear_mon();
      wr(5'd0, (32'(v.c1) << 8) | (32'(v.dp) << 7) | (32'(v.idx) << 4) |
               (32'(v.fs) << 2) | (32'(v.at) << 1) | 32'd1);
      wait_idle();
      // R7 done flag
      rd(5'd1, d); check(d === 32'h2, "R7", "status after cycle", d, 32'h2);
      wr(5'd1, 32'h2);
      rd(5'd1, d); check(d === 32'h0, "R7", "done cleared", d, 32'h0);

      check(fcnt == nf, tag, "frame count", 32'(fcnt), 32'(nf));
      for (int f = 0; f < nf && f < fcnt; f++) begin
        bad = -1;
        if (flen_m[f] != exl[f]) bad = 999;
        else for (int k = exl[f] - 1; k >= 0; k--) if (fb[f][k] !== ex[f][k]) bad = k;
        if (bad == 999) check(0, tag, "frame length", 32'(flen_m[f]), 32'(exl[f]));
        else if (bad >= 0) check(0, tag, "frame byte", {24'h0, fb[f][bad]}, {24'h0, ex[f][bad]});
        else check(1, tag, "frame", 0, 0);
      end
      if (v.dp && ty % 2 == 0) begin
        // R5 captured read bytes
        for (int j = 0; j <= int'(v.c1); j++) begin
          logic [7:0] e;
          e = 8'hC3 ^ 8'(hdr + j);
          if (j % 4 == 0) rd(5'(8 + j / 4), d);
          check(d[8*(j%4) +: 8] === e, "R5", "read buffer", {24'h0, d[8*(j%4) +: 8]}, {24'h0, e});
        end
      end
      if (v.at)
        check(gap_ns >= 2 * hp * 8, "R6", "prefix gap ns", 32'(gap_ns), 32'(2 * hp * 8));
      // R11 clock period per select
      check(per_ns == 2 * hp * 8, "R11", "sck period ns", 32'(per_ns), 32'(2 * hp * 8));
    end

    // R8 go while busy
    fill_buf(9);
    wr(5'd2, 32'h000200);
    clear_mon();
    wr(5'd0, 32'h00003FF5);
    repeat (40) @(negedge clk);
    wr(5'd0, 32'h00000015);
    rd(5'd1, d); check(d === 32'h5, "R8", "status busy+err", d, 32'h5);
    wait_idle();
    check(fcnt == 1, "R8", "frame count", 32'(fcnt), 1);
    check(flen_m[0] == 68, "R8", "frame length", 32'(flen_m[0]), 68);
    check(fb[0][0] === menu_op(7), "R8", "opcode kept", {24'h0, fb[0][0]}, {24'h0, menu_op(7)});
    rd(5'd1, d); check(d === 32'h6, "R8", "done+err", d, 32'h6);
    wr(5'd1, 32'h4);
    rd(5'd1, d); check(d === 32'h2, "R7", "err cleared only", d, 32'h2);
    wr(5'd1, 32'h2);

    // R9 protection veto
    clear_mon();
    prot_deny = 1'b1;
    wr(5'd0, 32'h00000015);
    prot_deny = 1'b0;
    rd(5'd1, d); check(d === 32'h4, "R9", "status after veto", d, 32'h4);
    repeat (200) @(negedge clk);
    check(fcnt == 0, "R9", "no frame", 32'(fcnt), 0);
    wr(5'd1, 32'h4);

    // R10 lockdown
    wr(5'd7, 32'h1);
    wr(5'd3, 32'h0); wr(5'd4, 32'h0); wr(5'd5, 32'h0); wr(5'd6, 32'h99);
    rd(5'd3, d); check(d === {menu_op(3), menu_op(2), menu_op(1), menu_op(0)}, "R10", "menu locked", d,
                       {menu_op(3), menu_op(2), menu_op(1), menu_op(0)});
    rd(5'd5, d); check(d === 32'hE4E4, "R10", "types locked", d, 32'hE4E4);
    rd(5'd6, d); check(d === 32'h06, "R10", "prefix locked", d, 32'h06);
    rd(5'd7, d); check(d === 32'h1, "R10", "lock set", d, 32'h1);
    wr(5'd2, 32'h000042); rd(5'd2, d);
    check(d === 32'h42, "R10", "addr still writable", d, 32'h42);
    clear_mon();
    wr(5'd0, 32'h00000017);
    wait_idle();
    check(fcnt == 2 && fb[0][0] === 8'h06 && fb[1][0] === menu_op(1), "R10", "locked cycle bytes",
          {fb[0][0], fb[1][0]}, {8'h06, menu_op(1)});
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(5'd7, d); check(d === 0, "R10", "lock cleared by reset", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule